// File: doc/BRIEF.md
# DMA Descriptor Error Monitor

This block screens a DMA channel's transfer descriptor at the moment the descriptor is loaded. It also gathers the error events that arise while the transfer runs, and keeps one global error status. A descriptor check is presented for one cycle on `chk_valid`. The block then tests the following rules:

- the source and destination addresses are aligned to their access sizes;
- the source and destination offsets are multiples of their access sizes;
- the minor byte count fits both access sizes;
- the starting and current iteration counts agree;
- when scatter/gather is on, the next-descriptor pointer lies on a 32-byte boundary.

Separate inputs report read-side and write-side bus errors and transfer cancellation. Each kind of error has its own sticky flag. The channel of the first recorded error is captured, and a summary valid bit shows that something is pending.

When halt-on-error is enabled, any error raises a global halt. While halt is up, the per-channel service requests are masked off from the grant outputs. Halt stays up until software pulses its clear. Flags are cleared with a write-one-to-clear mask strobe.

Top module: `desc_err_monitor`

## Requirements
- R1: A check whose source (destination) address has any bit below log2 of the source (destination) access size set raises flag bit 0 (bit 1) on the cycle after `chk_valid`. The access size in bytes is 2 raised to the 3-bit size code.
- R2: A check whose source (destination) offset is not a multiple of the source (destination) access size raises flag bit 2 (bit 3).
- R3: Flag bit 4 is raised when either of these holds: the minor byte count is not a multiple of both access sizes, or the starting and current iteration counts differ.
- R4: With `sg_en` high, a next-descriptor address with any of its low 5 bits nonzero raises flag bit 5. With `sg_en` low, the pointer has no effect.
- R5: `bus_err_valid` raises flag bit 6 when `bus_err_is_dst` is 0 and bit 7 when it is 1. `cancel_valid` raises flag bit 8.
- R6: `err_chan` captures the channel of an error event that arrives while `err_valid` is 0, and holds it while `err_valid` stays 1. In one cycle the descriptor check channel has priority over the bus-error channel, which has priority over the cancel channel.
- R7: `err_valid` is 1 exactly when at least one flag is set.
- R8: Flags are sticky. `clr_strobe` clears the flags selected by `clr_mask`. A flag set in the same cycle as its clear stays set.
- R9: With `halt_on_err` high, any error event sets `halt`. `halt` stays set until `halt_clr`, even after the flags are cleared. With `halt_on_err` low, errors leave `halt` at 0.
- R10: `svc_gnt` equals `svc_req` one cycle later while `halt` is 0, and is all zero on every cycle after a cycle in which `halt` was 1.
- R11: Synchronous reset clears flags, `err_chan`, `err_valid`, `halt` and `svc_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_on_err | input | 1 | Enable global halt on any error |
| chk_valid | input | 1 | Descriptor check strobe |
| chk_chan | input | CH_W | Channel of the descriptor being checked |
| src_addr | input | ADDR_W | Source address |
| dst_addr | input | ADDR_W | Destination address |
| src_off | input | OFF_W | Source signed offset |
| dst_off | input | OFF_W | Destination signed offset |
| src_size | input | SZ_W | Source access size code |
| dst_size | input | SZ_W | Destination access size code |
| minor_bytes | input | CNT_W | Minor loop byte count |
| begin_iter | input | ITER_W | Starting iteration count |
| cur_iter | input | ITER_W | Current iteration count |
| sg_en | input | 1 | Scatter/gather enable |
| next_desc | input | ADDR_W | Next-descriptor address |
| bus_err_valid | input | 1 | Bus error event |
| bus_err_is_dst | input | 1 | Bus error was on the write side |
| bus_err_chan | input | CH_W | Channel of the bus error |
| cancel_valid | input | 1 | Transfer cancelled event |
| cancel_chan | input | CH_W | Channel of the cancelled transfer |
| clr_strobe | input | 1 | Flag clear strobe |
| clr_mask | input | 9 | Flags to clear |
| halt_clr | input | 1 | Clear global halt |
| svc_req | input | NUM_CH | Channel service requests |
| err_flags | output | 9 | Sticky error flags |
| err_chan | output | CH_W | Channel of the first recorded error |
| err_valid | output | 1 | Any flag set |
| halt | output | 1 | Global halt |
| svc_gnt | output | NUM_CH | Service requests passed on when not halted |

## Verification
The hardest states to reach are the ones where events collide in a single cycle. One case is a descriptor failure and a bus error on different channels at the same time. Another is a flag clear that meets a new error of the same kind. A third is halt persisting after every flag has been wiped. The bench reaches them with directed steps that drive several strobes in one cycle. It samples the status after each step, then clears flags and halt separately, so that capture priority, set-over-clear and halt persistence are each seen at the ports.

// File: rtl/desc_chk_pkg.sv
package desc_chk_pkg;
  localparam int FLAG_N     = 9;
  localparam int F_SRC_ADDR = 0;
  localparam int F_DST_ADDR = 1;
  localparam int F_SRC_OFF  = 2;
  localparam int F_DST_OFF  = 3;
  localparam int F_COUNT    = 4;
  localparam int F_SG       = 5;
  localparam int F_SRC_BUS  = 6;
  localparam int F_DST_BUS  = 7;
  localparam int F_CANCEL   = 8;
  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/lowbit_chk.sv
// Flags a value that is not a multiple of 2**size_code.
module lowbit_chk #(
  parameter int W    = 32,
  parameter int SZ_W = 3
) (
  input  logic [W-1:0]    val,
  input  logic [SZ_W-1:0] size_code,
  output logic            bad
);
  logic [W-1:0] low_mask;
  always_comb begin
    low_mask = ~({W{1'b1}} << size_code);
    bad      = |(val & low_mask);
  end
endmodule

// File: rtl/desc_rules.sv
// Combinational descriptor rule evaluation, gated by the check strobe.
module desc_rules
  import desc_chk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 16,
  parameter int CNT_W   = 32,
  parameter int ITER_W  = 15,
  parameter int SZ_W    = 3,
  parameter int SG_BITS = 5
) (
  input  logic              chk_valid,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [OFF_W-1:0]  src_off,
  input  logic [OFF_W-1:0]  dst_off,
  input  logic [SZ_W-1:0]   src_size,
  input  logic [SZ_W-1:0]   dst_size,
  input  logic [CNT_W-1:0]  minor_bytes,
  input  logic [ITER_W-1:0] begin_iter,
  input  logic [ITER_W-1:0] cur_iter,
  input  logic              sg_en,
  input  logic [ADDR_W-1:0] next_desc,
  output flag_vec_t         found
);
  localparam int LW1 = (ADDR_W > OFF_W) ? ADDR_W : OFF_W;
  localparam int LW  = (LW1 > CNT_W) ? LW1 : CNT_W;
  localparam int NCHK = 6;

  logic [LW-1:0]   vals  [NCHK];
  logic [SZ_W-1:0] sizes [NCHK];
  logic [NCHK-1:0] bad;
  logic            unused_desc_hi;

  assign unused_desc_hi = ^next_desc[ADDR_W-1:SG_BITS];

  always_comb begin
    vals[0] = LW'(src_addr);    sizes[0] = src_size;
    vals[1] = LW'(dst_addr);    sizes[1] = dst_size;
    vals[2] = LW'(src_off);     sizes[2] = src_size;
    vals[3] = LW'(dst_off);     sizes[3] = dst_size;
    vals[4] = LW'(minor_bytes); sizes[4] = src_size;
    vals[5] = LW'(minor_bytes); sizes[5] = dst_size;
  end

  for (genvar k = 0; k < NCHK; k++) begin : g_align
    lowbit_chk #(.W(LW), .SZ_W(SZ_W)) u_lb (
      .val(vals[k]), .size_code(sizes[k]), .bad(bad[k])
    );
  end

  always_comb begin
    found = '0;
    if (chk_valid) begin
      found[F_SRC_ADDR] = bad[0];
      found[F_DST_ADDR] = bad[1];
      found[F_SRC_OFF]  = bad[2];
      found[F_DST_OFF]  = bad[3];
      found[F_COUNT]    = bad[4] | bad[5] | (begin_iter != cur_iter);
      found[F_SG]       = sg_en & (|next_desc[SG_BITS-1:0]);
    end
  end
endmodule

// File: rtl/err_status_reg.sv
// Sticky flags, first-error channel capture, summary valid and global halt.
module err_status_reg
  import desc_chk_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  flag_vec_t       chk_flags,
  input  logic [CH_W-1:0] chk_chan,
  input  logic            bus_err_valid,
  input  logic            bus_err_is_dst,
  input  logic [CH_W-1:0] bus_err_chan,
  input  logic            cancel_valid,
  input  logic [CH_W-1:0] cancel_chan,
  input  logic            clr_strobe,
  input  flag_vec_t       clr_mask,
  input  logic            halt_on_err,
  input  logic            halt_clr,
  output flag_vec_t       flags_q,
  output logic [CH_W-1:0] chan_q,
  output logic            valid_q,
  output logic            halt_q
);
  flag_vec_t       new_set, flags_nxt;
  logic            ev;
  logic [CH_W-1:0] ev_chan;

  always_comb begin
    new_set = chk_flags;
    if (bus_err_valid) begin
      if (bus_err_is_dst) new_set[F_DST_BUS] = 1'b1;
      else                new_set[F_SRC_BUS] = 1'b1;
    end
    if (cancel_valid) new_set[F_CANCEL] = 1'b1;
    ev = |new_set;

    if (|chk_flags)         ev_chan = chk_chan;
    else if (bus_err_valid) ev_chan = bus_err_chan;
    else                    ev_chan = cancel_chan;

    flags_nxt = (flags_q & ~(clr_strobe ? clr_mask : '0)) | new_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      chan_q  <= '0;
      valid_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      flags_q <= flags_nxt;
      valid_q <= |flags_nxt;
      if (ev && !valid_q) chan_q <= ev_chan;
      if (ev && halt_on_err) halt_q <= 1'b1;
      else if (halt_clr)     halt_q <= 1'b0;
    end
  end
endmodule

// File: rtl/svc_gate.sv
// Registered pass-through of service requests, blocked while halted.
module svc_gate #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_q,
  input  logic [NUM_CH-1:0] svc_req,
  output logic [NUM_CH-1:0] svc_gnt
);
  always_ff @(posedge clk) begin
    if (rst)         svc_gnt <= '0;
    else if (halt_q) svc_gnt <= '0;
    else             svc_gnt <= svc_req;
  end
endmodule

// File: rtl/desc_err_monitor.sv
module desc_err_monitor
  import desc_chk_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 16,
  parameter int CNT_W   = 32,
  parameter int ITER_W  = 15,
  parameter int SZ_W    = 3,
  parameter int SG_BITS = 5,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_on_err,
  input  logic              chk_valid,
  input  logic [CH_W-1:0]   chk_chan,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [OFF_W-1:0]  src_off,
  input  logic [OFF_W-1:0]  dst_off,
  input  logic [SZ_W-1:0]   src_size,
  input  logic [SZ_W-1:0]   dst_size,
  input  logic [CNT_W-1:0]  minor_bytes,
  input  logic [ITER_W-1:0] begin_iter,
  input  logic [ITER_W-1:0] cur_iter,
  input  logic              sg_en,
  input  logic [ADDR_W-1:0] next_desc,
  input  logic              bus_err_valid,
  input  logic              bus_err_is_dst,
  input  logic [CH_W-1:0]   bus_err_chan,
  input  logic              cancel_valid,
  input  logic [CH_W-1:0]   cancel_chan,
  input  logic              clr_strobe,
  input  logic [FLAG_N-1:0] clr_mask,
  input  logic              halt_clr,
  input  logic [NUM_CH-1:0] svc_req,
  output logic [FLAG_N-1:0] err_flags,
  output logic [CH_W-1:0]   err_chan,
  output logic              err_valid,
  output logic              halt,
  output logic [NUM_CH-1:0] svc_gnt
);
  flag_vec_t chk_flags;

  desc_rules #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W),
    .ITER_W(ITER_W), .SZ_W(SZ_W), .SG_BITS(SG_BITS)
  ) u_rules (
    .chk_valid(chk_valid), .src_addr(src_addr), .dst_addr(dst_addr),
    .src_off(src_off), .dst_off(dst_off), .src_size(src_size),
    .dst_size(dst_size), .minor_bytes(minor_bytes), .begin_iter(begin_iter),
    .cur_iter(cur_iter), .sg_en(sg_en), .next_desc(next_desc),
    .found(chk_flags)
  );

  err_status_reg #(.CH_W(CH_W)) u_status (
    .clk(clk), .rst(rst), .chk_flags(chk_flags), .chk_chan(chk_chan),
    .bus_err_valid(bus_err_valid), .bus_err_is_dst(bus_err_is_dst),
    .bus_err_chan(bus_err_chan), .cancel_valid(cancel_valid),
    .cancel_chan(cancel_chan), .clr_strobe(clr_strobe), .clr_mask(clr_mask),
    .halt_on_err(halt_on_err), .halt_clr(halt_clr),
    .flags_q(err_flags), .chan_q(err_chan), .valid_q(err_valid), .halt_q(halt)
  );

  svc_gate #(.NUM_CH(NUM_CH)) u_gate (
    .clk(clk), .rst(rst), .halt_q(halt), .svc_req(svc_req), .svc_gnt(svc_gnt)
  );
endmodule

// File: rtl/desc_err_monitor_chk.sv
module desc_err_monitor_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              halt_on_err,
  input logic              sg_en,
  input logic              chk_valid,
  input logic [ADDR_W-1:0] next_desc,
  input logic              bus_err_valid,
  input logic              bus_err_is_dst,
  input logic              cancel_valid,
  input logic              clr_strobe,
  input logic              halt_clr,
  input logic [8:0]        err_flags,
  input logic [CH_W-1:0]   err_chan,
  input logic              err_valid,
  input logic              halt,
  input logic [NUM_CH-1:0] svc_gnt
);
  logic unused_hi;
  assign unused_hi = ^next_desc[ADDR_W-1:5];

  // R4
  sg_align_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && sg_en && (next_desc[4:0] != 5'd0)) |=> err_flags[5]);

  // R5
  dst_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_err_valid && bus_err_is_dst) |=> err_flags[7]);

  // R5
  cancel_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cancel_valid |=> err_flags[8]);

  // R6
  chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !clr_strobe) |=> $stable(err_chan));

  // R7
  valid_sum_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid == (err_flags != 9'd0));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_strobe |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R9
  halt_set_chk: assert property (@(posedge clk) disable iff (rst)
    (halt_on_err && (bus_err_valid || cancel_valid)) |=> halt);

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !halt_clr) |=> halt);

  // R10
  gate_block_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> (svc_gnt == '0));
endmodule

bind desc_err_monitor desc_err_monitor_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_desc_err_monitor.sv
`timescale 1ns/1ps
module sim_desc_err_monitor;
  localparam int NUM_CH = 8;
  localparam int CH_W   = 3;

  typedef struct packed {
    logic [31:0] sa;
    logic [31:0] da;
    logic [15:0] so;
    logic [15:0] doff;
    logic [2:0]  ss;
    logic [2:0]  ds;
    logic [31:0] nb;
    logic [14:0] bi;
    logic [14:0] ci;
    logic        sg;
    logic [31:0] nd;
    logic [8:0]  exp;
  } vec_t;

  // Flag bits: 0 src addr, 1 dst addr, 2 src off, 3 dst off, 4 count,
  // 5 scatter/gather, 6 src bus, 7 dst bus, 8 cancel.
  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 32'd16, 15'd5, 15'd5, 1'b0, 32'h0,    9'h000},
    '{32'h1002, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 32'd16, 15'd5, 15'd5, 1'b0, 32'h0,    9'h001},
    '{32'h1000, 32'h2001, 16'd4, 16'd2, 3'd2, 3'd1, 32'd16, 15'd5, 15'd5, 1'b0, 32'h0,    9'h002},
    '{32'h1000, 32'h2000, 16'd3, 16'd4, 3'd1, 3'd2, 32'd16, 15'd5, 15'd5, 1'b0, 32'h0,    9'h004},
    '{32'h1000, 32'h2000, 16'd4, 16'hFFFE, 3'd2, 3'd2, 32'd16, 15'd5, 15'd5, 1'b0, 32'h0, 9'h008},
    '{32'h1000, 32'h2000, 16'd1, 16'd4, 3'd0, 3'd2, 32'd6,  15'd5, 15'd5, 1'b0, 32'h0,    9'h010},
    '{32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 32'd16, 15'd5, 15'd4, 1'b0, 32'h0,    9'h010},
    '{32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 32'd16, 15'd5, 15'd5, 1'b1, 32'h3010, 9'h020},
    '{32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 32'd16, 15'd5, 15'd5, 1'b1, 32'h3020, 9'h000},
    '{32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 32'd16, 15'd5, 15'd5, 1'b0, 32'h3011, 9'h000},
    '{32'h1001, 32'h2000, 16'd1, 16'd4, 3'd1, 3'd2, 32'd16, 15'd5, 15'd5, 1'b0, 32'h0,    9'h005}
  };

  logic clk = 0;
  logic rst = 1;
  logic halt_on_err = 0, chk_valid = 0, sg_en = 0;
  logic [CH_W-1:0] chk_chan = 0, bus_err_chan = 0, cancel_chan = 0;
  logic [31:0] src_addr = 0, dst_addr = 0, minor_bytes = 0, next_desc = 0;
  logic [15:0] src_off = 0, dst_off = 0;
  logic [2:0]  src_size = 0, dst_size = 0;
  logic [14:0] begin_iter = 0, cur_iter = 0;
  logic bus_err_valid = 0, bus_err_is_dst = 0, cancel_valid = 0;
  logic clr_strobe = 0, halt_clr = 0;
  logic [8:0] clr_mask = 0;
  logic [NUM_CH-1:0] svc_req = 0;
  logic [8:0] err_flags;
  logic [CH_W-1:0] err_chan;
  logic err_valid, halt;
  logic [NUM_CH-1:0] svc_gnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  desc_err_monitor #(.NUM_CH(NUM_CH)) u0 (
    .clk(clk), .rst(rst), .halt_on_err(halt_on_err), .chk_valid(chk_valid),
    .chk_chan(chk_chan), .src_addr(src_addr), .dst_addr(dst_addr),
    .src_off(src_off), .dst_off(dst_off), .src_size(src_size),
    .dst_size(dst_size), .minor_bytes(minor_bytes), .begin_iter(begin_iter),
    .cur_iter(cur_iter), .sg_en(sg_en), .next_desc(next_desc),
    .bus_err_valid(bus_err_valid), .bus_err_is_dst(bus_err_is_dst),
    .bus_err_chan(bus_err_chan), .cancel_valid(cancel_valid),
    .cancel_chan(cancel_chan), .clr_strobe(clr_strobe), .clr_mask(clr_mask),
    .halt_clr(halt_clr), .svc_req(svc_req), .err_flags(err_flags),
    .err_chan(err_chan), .err_valid(err_valid), .halt(halt), .svc_gnt(svc_gnt)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_ok();
    src_addr = 32'h1000; dst_addr = 32'h2000; src_off = 16'd4; dst_off = 16'd4;
    src_size = 3'd2; dst_size = 3'd2; minor_bytes = 32'd16;
    begin_iter = 15'd5; cur_iter = 15'd5; sg_en = 0; next_desc = 0;
  endtask

  task automatic clear_all();
    clr_strobe = 1; clr_mask = 9'h1FF; step(); clr_strobe = 0; clr_mask = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 0;
    // R11 reset state
    chk("R11 flags", 32'(err_flags), 0);
    chk("R11 valid", 32'(err_valid), 0);
    chk("R11 halt", 32'(halt), 0);
    chk("R11 gnt", 32'(svc_gnt), 0);

    // R1 R2 R3 R4 R7 R6: table of descriptor checks
    for (int i = 0; i < NV; i++) begin
      src_addr = TBL[i].sa; dst_addr = TBL[i].da; src_off = TBL[i].so;
      dst_off = TBL[i].doff; src_size = TBL[i].ss; dst_size = TBL[i].ds;
      minor_bytes = TBL[i].nb; begin_iter = TBL[i].bi; cur_iter = TBL[i].ci;
      sg_en = TBL[i].sg; next_desc = TBL[i].nd;
      chk_chan = CH_W'(i); chk_valid = 1;
      step();
      chk_valid = 0;
      chk($sformatf("R1 R2 R3 R4 vec%0d flags", i), 32'(err_flags), 32'(TBL[i].exp));
      chk($sformatf("R7 vec%0d valid", i), 32'(err_valid), 32'(TBL[i].exp != 0));
      if (TBL[i].exp != 0) chk($sformatf("R6 vec%0d chan", i), 32'(err_chan), 32'(i % NUM_CH));
      clear_all();
      chk($sformatf("R8 vec%0d cleared", i), 32'(err_flags), 0);
    end
    load_ok();

    // R10 pass-through
    svc_req = 8'hA5; step();
    chk("R10 gnt passes", 32'(svc_gnt), 32'h A5);

    // R5 R6 bus errors and cancel, first channel held
    bus_err_valid = 1; bus_err_is_dst = 0; bus_err_chan = 3; step(); bus_err_valid = 0;
    chk("R5 src bus flag", 32'(err_flags), 32'h040);
    chk("R6 first chan", 32'(err_chan), 3);
    bus_err_valid = 1; bus_err_is_dst = 1; bus_err_chan = 5; step(); bus_err_valid = 0;
    chk("R5 dst bus flag", 32'(err_flags), 32'h0C0);
    chk("R6 chan held", 32'(err_chan), 3);
    cancel_valid = 1; cancel_chan = 6; step(); cancel_valid = 0;
    chk("R5 cancel flag", 32'(err_flags), 32'h1C0);
    chk("R9 no halt when disabled", 32'(halt), 0);

    // R8 partial clear
    clr_strobe = 1; clr_mask = 9'h040; step(); clr_strobe = 0;
    chk("R8 partial clear", 32'(err_flags), 32'h180);
    chk("R7 still valid", 32'(err_valid), 1);
    clr_strobe = 1; clr_mask = 9'h180; step(); clr_strobe = 0;
    chk("R8 full clear", 32'(err_flags), 0);
    chk("R7 valid low", 32'(err_valid), 0);
    cancel_valid = 1; cancel_chan = 6; step(); cancel_valid = 0;
    chk("R6 recapture", 32'(err_chan), 6);

    // R8 set wins over clear
    clr_strobe = 1; clr_mask = 9'h100; cancel_valid = 1; cancel_chan = 2;
    step(); clr_strobe = 0; cancel_valid = 0;
    chk("R8 set over clear", 32'(err_flags), 32'h100);
    clear_all();

    // R6 priority: descriptor check over bus error
    src_addr = 32'h1003; chk_chan = 2; chk_valid = 1;
    bus_err_valid = 1; bus_err_is_dst = 0; bus_err_chan = 4;
    step(); chk_valid = 0; bus_err_valid = 0; load_ok();
    chk("R6 priority chan", 32'(err_chan), 2);
    chk("R1 R5 both flags", 32'(err_flags), 32'h041);
    clear_all();

    // R9 R10 halt
    halt_on_err = 1; svc_req = 8'hFF;
    bus_err_valid = 1; bus_err_is_dst = 1; bus_err_chan = 1; step(); bus_err_valid = 0;
    chk("R9 halt set", 32'(halt), 1);
    step();
    chk("R10 gnt blocked", 32'(svc_gnt), 0);
    clear_all();
    chk("R9 halt survives clear", 32'(halt), 1);
    chk("R10 still blocked", 32'(svc_gnt), 0);
    halt_clr = 1; step(); halt_clr = 0;
    chk("R9 halt cleared", 32'(halt), 0);
    step();
    chk("R10 gnt restored", 32'(svc_gnt), 32'hFF);

    // R11 reset mid-run
    cancel_valid = 1; step(); cancel_valid = 0;
    rst = 1; step(); rst = 0;
    chk("R11 reset flags", 32'(err_flags), 0);
    chk("R11 reset halt", 32'(halt), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule